// File: doc/BRIEF.md
# Running Median Filter with Sorted Window

This block computes a running median over the most recent N words of a sample stream, N being odd. The window is held as a physically sorted array of N slots, each slot pairing a sample with an age tag. For every accepted word the block removes the slot holding the oldest sample by closing the gap over it, then puts the new word into its ranked place by opening a gap above the smaller entries. The middle slot of the array is the median, which the block captures in an output register.

The parameter `SINGLE_CYCLE` picks how the update is scheduled. When it is set, the removal and the placement are computed together in one clock, and a word can be accepted on every cycle. When it is clear, the removal is written in one clock and the placement in the next. During the placement cycle the block drops `in_ready` and disregards `in_valid`. While the window is still filling, nothing is removed and the median flag stays low.

Top module: `median_window_filter`

## Requirements
- R1: Once N words have been accepted, `med_data` equals the value at rank (N+1)/2, counting from 1 in ascending order, among the last N accepted words.
- R2: `med_valid` is low until the Nth word after reset has been accepted. From the update that completes the Nth word onward it stays high.
- R3: Each accepted word removes exactly the one stored word that was accepted earliest. Repeated equal values in the stream do not disturb this.
- R4: With `SINGLE_CYCLE`=1, `in_ready` is always high. A word presented with `in_valid` on a rising edge is reflected in `med_data` and `med_valid` right after that edge.
- R5: With `SINGLE_CYCLE`=0, `in_ready` is low for exactly the one cycle after an accepted word. `in_valid` during that cycle has no effect. The result appears right after the second rising edge counted from acceptance.
- R6: While `rst_n` is low, `med_valid` is 0, `med_data` is 0 and the window is emptied. `in_ready` is 1 after reset.
- R7: The occupied slots of the stored array are always in non-decreasing order from slot 0 upward.
- R8: When the window is full and no update is half done, exactly one slot carries the maximum age tag N-1.
- R9: When no word is accepted, `med_data` and `med_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | New sample is offered |
| in_data | input | W | Sample word, unsigned |
| in_ready | output | 1 | Block can take a sample this cycle |
| med_valid | output | 1 | Window full, `med_data` is a true median |
| med_data | output | W | Registered median of the window |

## Verification
In the single-cycle variant the median of a word is due one edge after it is offered. The bench drives each word at a falling edge and samples the outputs at the next falling edge. In the two-cycle variant the result is due two edges after acceptance. The bench checks `in_ready` low at the intermediate falling edge, deliberately offers a different word there, and then checks the median one falling edge later against a model window that never saw that word. Hold behaviour is checked across idle cycles, and reset clearing is checked after the three-edge synchronizer delay.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_INSERT = 1'b1
  } mwf_phase_e;
endpackage

// File: rtl/mwf_oldest.sv
module mwf_oldest #(
  parameter int N  = 5,
  parameter int AW = 3
) (
  input  logic [N-1:0][AW-1:0] ages,
  output logic [AW-1:0]        old_idx
);
  // slot whose tag has reached N-1 holds the earliest sample
  always_comb begin
    old_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ages[i] == AW'(N - 1)) old_idx = AW'(i);
    end
  end
endmodule

// File: rtl/mwf_delete.sv
module mwf_delete #(
  parameter int N  = 5,
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0][W-1:0]  vals_in,
  input  logic [N-1:0][AW-1:0] ages_in,
  input  logic                 del_en,
  input  logic [AW-1:0]        del_idx,
  output logic [N-1:0][W-1:0]  vals_out,
  output logic [N-1:0][AW-1:0] ages_out
);
  // slots at and above the removed one take their upper neighbour
  for (genvar j = 0; j < N; j++) begin : g_slot
    if (j < N - 1) begin : g_shift
      logic take_up;
      assign take_up     = del_en && (AW'(j) >= del_idx);
      assign vals_out[j] = take_up ? vals_in[j+1] : vals_in[j];
      assign ages_out[j] = take_up ? ages_in[j+1] : ages_in[j];
    end else begin : g_top
      assign vals_out[j] = vals_in[j];
      assign ages_out[j] = ages_in[j];
    end
  end
endmodule

// File: rtl/mwf_insert.sv
module mwf_insert #(
  parameter int N  = 5,
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int CW = 3
) (
  input  logic [N-1:0][W-1:0]  vals_in,
  input  logic [N-1:0][AW-1:0] ages_in,
  input  logic [CW-1:0]        used,
  input  logic [W-1:0]         new_val,
  output logic [N-1:0][W-1:0]  vals_out,
  output logic [N-1:0][AW-1:0] ages_out
);
  logic [CW-1:0] pos;

  // rank of the new word: occupied entries not greater than it
  // (equal older entries stay below the newcomer)
  always_comb begin
    pos = '0;
    for (int j = 0; j < N; j++) begin
      if ((CW'(j) < used) && (vals_in[j] <= new_val)) pos = pos + CW'(1);
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_slot
    if (j == 0) begin : g_low
      always_comb begin
        if (CW'(j) < pos) begin
          vals_out[j] = vals_in[j];
          ages_out[j] = ages_in[j] + AW'(1);
        end else begin
          vals_out[j] = new_val;
          ages_out[j] = '0;
        end
      end
    end else begin : g_up
      always_comb begin
        if (CW'(j) < pos) begin
          vals_out[j] = vals_in[j];
          ages_out[j] = ages_in[j] + AW'(1);
        end else if (CW'(j) == pos) begin
          vals_out[j] = new_val;
          ages_out[j] = '0;
        end else begin
          vals_out[j] = vals_in[j-1];
          ages_out[j] = ages_in[j-1] + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/median_window_filter.sv
module median_window_filter
  import mwf_pkg::*;
#(
  parameter int W            = 8,
  parameter int N            = 5,
  parameter bit SINGLE_CYCLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         med_valid,
  output logic [W-1:0] med_data
);
  localparam int AW  = (N > 1) ? $clog2(N) : 1;
  localparam int CW  = $clog2(N + 1);
  localparam int MID = (N - 1) / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  // state
  logic [N-1:0][W-1:0]  vals_q, vals_d;
  logic [N-1:0][AW-1:0] ages_q, ages_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [W-1:0]         x_q, x_d;
  mwf_phase_e           phase_q, phase_d;
  logic                 medv_q, medv_d;
  logic [W-1:0]         medd_q, medd_d;
  logic                 upd_en;

  // datapath
  logic                 full;
  logic [AW-1:0]        old_idx;
  logic [N-1:0][W-1:0]  dv, iv, ins_vals;
  logic [N-1:0][AW-1:0] da, ia, ins_ages;
  logic [CW-1:0]        cnt_del, ins_cnt;
  logic [W-1:0]         ins_x;

  assign full    = (cnt_q == CW'(N));
  assign cnt_del = full ? CW'(N - 1) : cnt_q;

  mwf_oldest #(.N(N), .AW(AW)) u_oldest (
    .ages    (ages_q),
    .old_idx (old_idx)
  );

  mwf_delete #(.N(N), .W(W), .AW(AW)) u_delete (
    .vals_in  (vals_q),
    .ages_in  (ages_q),
    .del_en   (full),
    .del_idx  (old_idx),
    .vals_out (dv),
    .ages_out (da)
  );

  mwf_insert #(.N(N), .W(W), .AW(AW), .CW(CW)) u_insert (
    .vals_in  (ins_vals),
    .ages_in  (ins_ages),
    .used     (ins_cnt),
    .new_val  (ins_x),
    .vals_out (iv),
    .ages_out (ia)
  );

  if (SINGLE_CYCLE) begin : g_one
    // removal feeds placement within the same clock
    assign ins_vals = dv;
    assign ins_ages = da;
    assign ins_cnt  = cnt_del;
    assign ins_x    = in_data;
    assign in_ready = 1'b1;
    assign upd_en   = in_valid;

    always_comb begin
      vals_d  = vals_q;
      ages_d  = ages_q;
      cnt_d   = cnt_q;
      x_d     = x_q;
      phase_d = phase_q;
      medv_d  = medv_q;
      medd_d  = medd_q;
      if (in_valid) begin
        vals_d = iv;
        ages_d = ia;
        cnt_d  = cnt_del + CW'(1);
        medd_d = iv[MID];
        medv_d = (cnt_del == CW'(N - 1));
      end
    end
  end else begin : g_two
    // removal written first, placement from the registered array next
    logic accept;
    assign ins_vals = vals_q;
    assign ins_ages = ages_q;
    assign ins_cnt  = cnt_q;
    assign ins_x    = x_q;
    assign in_ready = (phase_q == PH_IDLE);
    assign accept   = in_valid && in_ready;
    assign upd_en   = accept || (phase_q == PH_INSERT);

    always_comb begin
      vals_d  = vals_q;
      ages_d  = ages_q;
      cnt_d   = cnt_q;
      x_d     = x_q;
      phase_d = phase_q;
      medv_d  = medv_q;
      medd_d  = medd_q;
      if (phase_q == PH_INSERT) begin
        vals_d  = iv;
        ages_d  = ia;
        cnt_d   = cnt_q + CW'(1);
        medd_d  = iv[MID];
        medv_d  = (cnt_q == CW'(N - 1));
        phase_d = PH_IDLE;
      end else if (accept) begin
        vals_d  = dv;
        ages_d  = da;
        cnt_d   = cnt_del;
        x_d     = in_data;
        phase_d = PH_INSERT;
      end
    end

    // a taken word blocks the next cycle
    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!arst_n)
      accept |=> !in_ready);
    // placement cycle always returns to idle
    assert_ready_back_R5: assert property (@(posedge clk) disable iff (!arst_n)
      !in_ready |=> in_ready);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vals_q  <= '0;
      ages_q  <= '0;
      cnt_q   <= '0;
      x_q     <= '0;
      phase_q <= PH_IDLE;
      medv_q  <= 1'b0;
      medd_q  <= '0;
    end else if (upd_en) begin
      vals_q  <= vals_d;
      ages_q  <= ages_d;
      cnt_q   <= cnt_d;
      x_q     <= x_d;
      phase_q <= phase_d;
      medv_q  <= medv_d;
      medd_q  <= medd_d;
    end
  end

  assign med_valid = medv_q;
  assign med_data  = medd_q;

  // checks on the stored window
  logic [N-1:0] age_top;
  always_comb begin
    for (int i = 0; i < N; i++) age_top[i] = (ages_q[i] == AW'(N - 1));
  end

  for (genvar i = 1; i < N; i++) begin : g_order_chk
    assert_sorted_R7: assert property (@(posedge clk) disable iff (!arst_n)
      (cnt_q > CW'(i)) |-> (vals_q[i-1] <= vals_q[i]));
  end

  assert_one_oldest_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (full && phase_q == PH_IDLE) |-> ($countones(age_top) == 1));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!arst_n)
    med_valid |=> med_valid);

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_q <= CW'(N)) && (med_valid || cnt_q != CW'(N) || phase_q == PH_INSERT
                          || !full));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!arst_n)
    !upd_en |=> ($stable(med_data) && $stable(med_valid)));
endmodule

// File: tb/median_window_filter_test.sv
module median_window_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int N = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rst_n;
  logic         v1, v2;
  logic [W-1:0] d1, d2;
  logic         r1, r2, mv1, mv2;
  logic [W-1:0] md1, md2;

  median_window_filter #(.W(W), .N(N), .SINGLE_CYCLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_data(d1),
    .in_ready(r1), .med_valid(mv1), .med_data(md1)
  );

  median_window_filter #(.W(W), .N(N), .SINGLE_CYCLE(1'b0)) uut_two (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_data(d2),
    .in_ready(r2), .med_valid(mv2), .med_data(md2)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int hist[N];
  int hcnt = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(input int x);
    for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    if (hcnt < N) hcnt++;
  endtask

  function automatic int model_median();
    int s[N];
    int t;
    for (int i = 0; i < N; i++) s[i] = hist[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    return s[(N - 1) / 2];
  endfunction

  function automatic int stim(input int pat, input int i);
    case (pat)
      0: return (i * 7 + 3) % 16;
      1: return (i % 4 == 3) ? 2 : 9;
      2: return i % 16;
      3: return 15 - (i % 16);
      4: return (i * i + i / 3) % 16;
      default: return (i % 2 == 0) ? 0 : 15;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 valid in reset", int'(mv1), 0);
    check("R6 valid in reset two", int'(mv2), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hcnt = 0;
    for (int i = 0; i < N; i++) hist[i] = 0;
    check("R6 data after reset", int'(md1), 0);
    check("R6 data after reset two", int'(md2), 0);
    check("R6 ready after reset", int'(r2), 1);
  endtask

  task automatic push_one(input int x);
    @(negedge clk);
    v1 = 1'b1;
    d1 = W'(x);
    @(negedge clk);
    v1 = 1'b0;
    model_push(x);
    check("R2 R4 valid", int'(mv1), (hcnt == N) ? 1 : 0);
    check("R4 ready high", int'(r1), 1);
    if (hcnt == N) check("R1 R3 R7 R8 median", int'(md1), model_median());
  endtask

  task automatic push_two(input int x);
    @(negedge clk);
    check("R5 ready idle", int'(r2), 1);
    v2 = 1'b1;
    d2 = W'(x);
    @(negedge clk);
    check("R5 ready low", int'(r2), 0);
    d2 = W'(x ^ 4'hA);
    @(negedge clk);
    v2 = 1'b0;
    model_push(x);
    check("R2 R5 valid", int'(mv2), (hcnt == N) ? 1 : 0);
    check("R5 ready back", int'(r2), 1);
    if (hcnt == N) check("R1 R3 R5 R7 R8 median", int'(md2), model_median());
  endtask

  initial begin
    int keep;
    rst_n = 1'b0;
    v1 = 1'b0; v2 = 1'b0; d1 = '0; d2 = '0;
    do_reset();
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < 20; i++) push_one(stim(p, i));
    keep = int'(md1);
    repeat (3) @(negedge clk);
    check("R9 hold data", int'(md1), keep);
    check("R9 hold valid", int'(mv1), 1);

    do_reset();
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < 20; i++) push_two(stim(p, i));
    keep = int'(md2);
    repeat (3) @(negedge clk);
    check("R9 hold data two", int'(md2), keep);

    do_reset();
    for (int i = 0; i < N - 1; i++) push_one(i + 5);
    check("R2 partial fill", int'(mv1), 0);
    do_reset();
    for (int i = 0; i < N; i++) push_two(12 - i);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule